// File: doc/BRIEF.md
# FIFO with programmable almost-empty flag

This block is a single-clock first-in first-out buffer that holds up to 2048 words of 18 bits. Words written with `wr_en` come back out in order through a registered read port driven by `rd_en`. The block raises no error on misuse. A write into a full buffer is dropped. A read from an empty buffer is dropped, and `rd_data` keeps its old value.

Three active-low status flags tell the consumer how much data is waiting. `empty_n` is low when nothing is stored. `almost_empty_n` is low when the occupancy is at or below a programmable mark. The occupancy is the write pointer minus the read pointer, taken modulo the pointer range. `empty2_n` repeats `empty_n` one clock later, for logic that wants a delayed copy. The mark resets to 127 words. Software can change it at any time through `mark_load` and `mark_value`. A value above the buffer depth is refused, and the old mark stays in force.

Top module: `fifo_pae`

## Requirements
- R1: When `rst` is high at a clock edge, the next outputs are `empty_n`=0, `almost_empty_n`=0, `empty2_n`=0 and `rd_data`=0, and the mark returns to `MARK_RESET` (127 by default).
- R2: Accepted words are read out in exactly the order in which they were written.
- R3: A write while the buffer holds `DEPTH` words is dropped, so the occupancy never exceeds `DEPTH`.
- R4: A read while the buffer is empty is dropped: `rd_data` and the occupancy stay unchanged.
- R5: After an accepted read, `rd_data` shows the oldest word from the clock edge that accepts the read.
- R6: `empty_n` is updated on every clock edge. It is 0 exactly when the occupancy after that edge is zero.
- R7: `almost_empty_n` is 0 exactly when the occupancy after the edge is less than the mark plus one, that is, at or below the mark.
- R8: A mark load with `mark_value` <= `DEPTH` takes effect at the same edge, and the flag at that edge already uses the new mark. A load with a larger value leaves the mark unchanged.
- R9: `empty2_n` equals the value that `empty_n` had one clock earlier.
- R10: Occupancy is the pointer difference modulo the pointer range. The flags and the data stay correct across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| mark_load | input | 1 | Load a new almost-empty mark |
| mark_value | input | AW+1 | Mark to load (0..DEPTH) |
| empty_n | output | 1 | Low when the buffer is empty |
| almost_empty_n | output | 1 | Low when occupancy <= mark |
| empty2_n | output | 1 | `empty_n` delayed by one clock |

## Verification
`rd_data`, `empty_n` and `almost_empty_n` all change at the edge that accepts a write, read or mark load. None of them takes an extra cycle. `empty2_n` follows one edge after `empty_n`. The bench drives inputs on the falling edge and samples every output 1 ns after the next rising edge. At that moment it compares against a model that has been advanced by exactly that one edge, and it keeps the previous empty value for the lagging flag.

// File: rtl/fifo_pae_pkg.sv
package fifo_pae_pkg;

    // Which of the two requested operations the buffer accepts this cycle.
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } fifo_ops_t;

    // Registered status, all active low.
    typedef struct packed {
        logic empty_n;
        logic low_n;
        logic empty2_n;
    } fifo_flags_t;

    localparam fifo_flags_t FLAGS_RESET = '{empty_n: 1'b0, low_n: 1'b0, empty2_n: 1'b0};

    // A full buffer drops writes; an empty buffer drops reads.
    function automatic fifo_ops_t accept_ops(input logic wr, input logic rd,
                                             input logic is_full, input logic is_empty);
        fifo_ops_t o;
        o.wr_ok = wr && !is_full;
        o.rd_ok = rd && !is_empty;
        return o;
    endfunction

endpackage

// File: rtl/fifo_pae_ptr.sv
module fifo_pae_ptr
    import fifo_pae_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output fifo_ops_t     ops,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occ_next
);
    localparam logic [AW:0] OCC_FULL = (AW+1)'(DEPTH);

    // Pointers carry one extra bit so that full and empty differ.
    logic [AW:0] wr_ptr, rd_ptr, occ;

    always_comb begin
        occ      = wr_ptr - rd_ptr;
        ops      = accept_ops(wr_en, rd_en, occ == OCC_FULL, occ == '0);
        occ_next = occ + {{AW{1'b0}}, ops.wr_ok} - {{AW{1'b0}}, ops.rd_ok};
        wr_addr  = wr_ptr[AW-1:0];
        rd_addr  = rd_ptr[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (ops.wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (ops.rd_ok) rd_ptr <= rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/fifo_pae_mem.sv
module fifo_pae_mem
    import fifo_pae_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 18,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_ops_t        ops,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (ops.wr_ok) store[wr_addr] <= wr_data;
    end

    // Output register: loads only on an accepted read, otherwise holds.
    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (ops.rd_ok) rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/fifo_pae_flags.sv
module fifo_pae_flags
    import fifo_pae_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int MARK_RESET = 127,
    localparam int AW = $clog2(DEPTH),
    localparam int MW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW:0]   occ_next,
    input  logic          mark_load,
    input  logic [MW-1:0] mark_value,
    output fifo_flags_t   flags
);
    localparam logic [MW-1:0] MARK_MAX  = MW'(DEPTH);
    localparam logic [MW-1:0] MARK_INIT = MW'(MARK_RESET);

    logic [MW-1:0] mark, mark_next;

    // Values above the depth are refused; the current mark stays.
    always_comb begin
        mark_next = mark;
        if (mark_load && (mark_value <= MARK_MAX)) mark_next = mark_value;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mark  <= MARK_INIT;
            flags <= FLAGS_RESET;
        end else begin
            mark           <= mark_next;
            flags.empty_n  <= (occ_next != '0);
            flags.low_n    <= (occ_next > mark_next);
            flags.empty2_n <= flags.empty_n;
        end
    end

endmodule

// File: rtl/fifo_pae.sv
module fifo_pae
    import fifo_pae_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int WIDTH      = 18,
    parameter int MARK_RESET = 127,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             mark_load,
    input  logic [AW:0]      mark_value,
    output logic             empty_n,
    output logic             almost_empty_n,
    output logic             empty2_n
);
    fifo_ops_t     ops;
    fifo_flags_t   flags;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   occ_next;

    fifo_pae_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .ops(ops), .wr_addr(wr_addr), .rd_addr(rd_addr), .occ_next(occ_next)
    );

    fifo_pae_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk(clk), .rst(rst), .ops(ops), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    fifo_pae_flags #(.DEPTH(DEPTH), .MARK_RESET(MARK_RESET)) u_flags (
        .clk(clk), .rst(rst), .occ_next(occ_next),
        .mark_load(mark_load), .mark_value(mark_value), .flags(flags)
    );

    assign empty_n        = flags.empty_n;
    assign almost_empty_n = flags.low_n;
    assign empty2_n       = flags.empty2_n;

endmodule

// File: rtl/fifo_pae_chk.sv
module fifo_pae_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             empty_n,
    input logic             almost_empty_n,
    input logic             empty2_n
);
    // R1: the cycle after reset releases, all flags are low
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!empty_n && !almost_empty_n && !empty2_n));

    // R4: a read into an empty buffer leaves the output word alone
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en) |=> $stable(rd_data));

    // R6: a write into an empty buffer is always accepted
    p_write_fills_r6: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && wr_en) |=> empty_n);

    // R6: without a read, a non-empty buffer stays non-empty
    p_hold_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        (empty_n && !rd_en) |=> empty_n);

    // R7: zero occupancy is always at or below any mark
    p_empty_is_low_r7: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !almost_empty_n);

    // R9: the second flag lags the first by one clock
    p_lag_copy_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (empty2_n == $past(empty_n)));

endmodule

bind fifo_pae fifo_pae_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n), .empty2_n(empty2_n)
);

// File: tb/fifo_pae_bench.sv
`timescale 1ns/1ps
module fifo_pae_bench;
    localparam int DEPTH = 16;
    localparam int WIDTH = 18;
    localparam int MARK_RESET = 7;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, mark_load = 1'b0;
    logic [WIDTH-1:0] wr_data = '0, rd_data;
    logic [AW:0]      mark_value = '0;
    logic             empty_n, almost_empty_n, empty2_n;

    fifo_pae #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MARK_RESET(MARK_RESET)) u_fifo_pae (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .mark_load(mark_load), .mark_value(mark_value),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n), .empty2_n(empty2_n)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference model
    logic [WIDTH-1:0] mq[$];
    int               m_cnt = 0, m_mark = MARK_RESET;
    logic [WIDTH-1:0] m_rd = '0, wseq = 18'h100;
    logic             m_e = 0, m_ae = 0, m_e2 = 0;

    task automatic chk1(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string ph);
        chk1("R5", {ph, " rd_data"}, 32'(rd_data), 32'(m_rd));
        chk1("R6", {ph, " empty_n"}, 32'(empty_n), 32'(m_e));
        chk1("R7", {ph, " almost_empty_n"}, 32'(almost_empty_n), 32'(m_ae));
        chk1("R9", {ph, " empty2_n"}, 32'(empty2_n), 32'(m_e2));
    endtask

    task automatic step(bit w, bit r, bit ld, int v, string ph);
        bit wok, rok;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = wseq; mark_load = ld; mark_value = (AW+1)'(v);
        @(posedge clk);
        wok = w && (m_cnt < DEPTH);
        rok = r && (m_cnt > 0);
        if (rok) begin m_rd = mq.pop_front(); m_cnt--; end
        if (wok) begin mq.push_back(wseq); m_cnt++; wseq = wseq + 18'h3; end
        if (ld && v <= DEPTH) m_mark = v;
        m_e2 = m_e;
        m_e  = (m_cnt != 0);
        m_ae = (m_cnt > m_mark);
        #1;
        check_all(ph);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 0; rd_en = 0; mark_load = 0;
        repeat (2) @(posedge clk);
        #1;
        mq.delete(); m_cnt = 0; m_mark = MARK_RESET;
        m_rd = '0; m_e = 0; m_ae = 0; m_e2 = 0;
        check_all("R1 reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Fill to full then drain to empty, checking every cycle.
    task automatic fill_drain(string ph);
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, ph);
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, ph);
    endtask

    initial begin
        int reads;
        do_reset();

        // R1: reset mark in force; R7 threshold sweep over all occupancies
        fill_drain("R1 R7 default mark");

        // R3: writes into a full buffer are dropped
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 0, "R3 overfill");
        reads = 0;
        while (empty_n && reads < DEPTH + 4) begin
            step(0, 1, 0, 0, "R2 R3 drain");
            reads++;
        end
        chk1("R3", "words read back after overfill", 32'(reads), 32'(DEPTH));

        // R4: reads on empty do nothing visible
        step(1, 0, 0, 0, "R4 prime");
        step(0, 1, 0, 0, "R4 prime");
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 0, 0, "R4 empty read");
            chk1("R4", "rd_data held", 32'(rd_data), 32'(mq.size() == 0 ? m_rd : '0));
        end

        // R8: every mark value, legal and refused, swept over occupancy
        for (int v = 0; v <= DEPTH + 3; v++) begin
            step(0, 0, 1, v, "R8 load");
            fill_drain("R8 sweep");
        end

        // R8: load together with a write, new mark applies at that edge
        step(0, 0, 1, 2, "R8 set");
        step(1, 0, 0, 0, "R8 pre");
        step(1, 0, 0, 0, "R8 pre");
        step(1, 0, 1, 3, "R8 same-edge");
        chk1("R8", "flag with new mark at same edge", 32'(almost_empty_n), 32'(0));
        while (m_cnt > 0) step(0, 1, 0, 0, "R8 drain");

        // R10: long mixed traffic with many wraps and occasional loads
        for (int blk = 0; blk < 8; blk++) begin
            for (int i = 0; i < 500; i++) begin
                int pw = (blk % 2 == 0) ? 3 : 1;
                bit w  = ($urandom % 4) < pw;
                bit r  = ($urandom % 4) >= pw - 1;
                bit ld = ($urandom % 40) == 0;
                step(w, r, ld, int'($urandom % (DEPTH + 4)), "R10 mixed");
            end
        end

        // R1: reset mid-stream restores flags and mark
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R1 pre");
        do_reset();
        fill_drain("R1 after reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired before the sequence finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule